// File: doc/BRIEF.md
# Circular Debug State Trace Buffer

This block is a small trace memory that sits beside a processor's bus and records snapshots of its activity without ever holding the processor back. Each snapshot holds the 16-bit address bus, the 16-bit data bus and a handful of CPU control bits. All three are taken at the clock edge where the chosen capture condition is true. The memory is a ring of eight slots. Once it is full, every new snapshot replaces the oldest one.

The capture condition comes from one of four sources, chosen by a select input: a basic trigger, a combined trigger, the trigger sequencer's output, or every clock cycle. If the qualifier is fed with instruction fetches, the ring keeps the last eight executed instructions. If it is fed with writes to one address, the newest entry always carries the latest value written to that variable, so the ring works as a live watch.

A debug host reads entries through a registered read port while capture continues. Read index 0 is the newest entry. The host also sees the write pointer, a fill count that saturates at the depth, and a flag that records an overwrite. A freeze input stops capture so the contents stay still while the host reads them out. A clear input empties the ring.

Top module: `dbg_trace_ring`

## Requirements
- R1: After reset, the write pointer is 0, the fill count is 0, the overwrite flag is 0 and the read acknowledge is 0.
- R2: The two-bit source select picks the capture qualifier, with the encoding 0 = basic trigger, 1 = combined trigger, 2 = sequencer output, 3 = every cycle. A snapshot is taken only at an edge where the selected qualifier is high, and the trigger inputs that are not selected have no effect.
- R3: A snapshot stores the address, data and control inputs present at the capture edge. A later read returns them unchanged.
- R4: A read request sampled at an edge, with index k, gives a read acknowledge of 1 for exactly the following cycle. In that cycle the read outputs hold the k-th newest entry, where k = 0 is the newest.
- R5: The ring holds the eight most recent snapshots. After more than eight captures, index 7 returns the eighth newest snapshot, and older ones are gone.
- R6: Each capture advances the write pointer by one, modulo 8. The fill count rises by one per capture and saturates at 8.
- R7: The overwrite flag goes to 1 at the first capture that happens while the fill count is 8. It then stays at 1 until a clear.
- R8: While freeze is 1, no capture happens in any mode. The pointer, the count, the overwrite flag and the stored entries all stay unchanged.
- R9: A clear sets the pointer, the count and the overwrite flag to 0 at the next edge. It wins over a capture in the same cycle, and afterwards every read reports a miss.
- R10: A read and a capture at the same edge return the contents from before that capture.
- R11: A read whose index is not below the fill count returns hit = 0, with the address, data and control outputs all 0.
- R12: Read requests do not change the pointer, the count, the overwrite flag or the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Address bus sampled at capture |
| cpu_data | input | 16 | Data bus sampled at capture |
| cpu_ctl | input | 4 | CPU control bits sampled at capture |
| trig_basic | input | 1 | Basic trigger qualifier |
| trig_comb | input | 1 | Combined trigger qualifier |
| trig_seq | input | 1 | Sequencer output qualifier |
| src_sel | input | 2 | Qualifier select (0 basic, 1 combined, 2 sequencer, 3 every cycle) |
| freeze | input | 1 | Stops capture while high |
| clear | input | 1 | Empties the ring |
| rd_req | input | 1 | Host read request |
| rd_idx | input | 3 | Age index of the requested entry, 0 = newest |
| rd_ack | output | 1 | Read result valid |
| rd_hit | output | 1 | Requested entry exists |
| rd_addr | output | 16 | Address field of the read entry |
| rd_data | output | 16 | Data field of the read entry |
| rd_ctl | output | 4 | Control field of the read entry |
| wr_ptr | output | 3 | Slot the next capture writes |
| fill_cnt | output | 4 | Number of valid entries, saturating at 8 |
| wrapped | output | 1 | An entry has been overwritten since the last clear |

## Verification
Both the status outputs and the read results are registered. A capture or clear at an edge is visible on the pointer, count and flag one cycle later. A read request is answered in the cycle that follows the edge that sampled it. Each read pushes its expected entry into a scoreboard, computed from a reference model before that cycle's capture is applied, and tagged with the cycle number in which it is due. The monitor samples at the falling edge and compares only when that cycle number is reached; an acknowledge in any other cycle is counted as an error. Status is compared one time step after each rising edge, against a model advanced by exactly that edge.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
   typedef enum logic [1:0] {
      SRC_BASIC  = 2'd0,
      SRC_COMB   = 2'd1,
      SRC_SEQ    = 2'd2,
      SRC_ALWAYS = 2'd3
   } dtr_src_e;
endpackage

// File: rtl/dtr_qualifier.sv
module dtr_qualifier
   import dtr_pkg::*;
(
   input  logic       trig_basic,
   input  logic       trig_comb,
   input  logic       trig_seq,
   input  logic [1:0] src_sel,
   input  logic       freeze,
   output logic       cap_fire
);
   logic src_hit;

   always_comb begin
      unique case (dtr_src_e'(src_sel))
         SRC_BASIC:  src_hit = trig_basic;
         SRC_COMB:   src_hit = trig_comb;
         SRC_SEQ:    src_hit = trig_seq;
         default:    src_hit = 1'b1;
      endcase
      cap_fire = src_hit & ~freeze;
   end
endmodule

// File: rtl/dtr_ctrl.sv
module dtr_ctrl #(
   parameter int DEPTH = 8,
   parameter int PW    = 3,
   parameter int CNTW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            cap_fire,
   output logic            wr_en,
   output logic [PW-1:0]   wr_ptr,
   output logic [CNTW-1:0] fill_cnt,
   output logic            wrapped
);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

   logic [PW-1:0] ptr_nxt;

   assign wr_en = cap_fire & ~clear;

   generate
      if (POW2) begin : g_ptr_pow2
         assign ptr_nxt = wr_ptr + PW'(1);
      end else begin : g_ptr_mod
         assign ptr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         fill_cnt <= '0;
         wrapped  <= 1'b0;
      end else if (clear) begin
         wr_ptr   <= '0;
         fill_cnt <= '0;
         wrapped  <= 1'b0;
      end else if (wr_en) begin
         wr_ptr <= ptr_nxt;
         if (fill_cnt == FULL) wrapped  <= 1'b1;
         else                  fill_cnt <= fill_cnt + CNTW'(1);
      end
   end
endmodule

// File: rtl/dtr_store.sv
module dtr_store #(
   parameter int DEPTH = 8,
   parameter int EW    = 36,
   parameter int PW    = 3,
   parameter int CNTW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [PW-1:0]   wr_ptr,
   input  logic [EW-1:0]   wr_entry,
   input  logic [CNTW-1:0] fill_cnt,
   input  logic            rd_req,
   input  logic [PW-1:0]   rd_idx,
   output logic            rd_ack,
   output logic            rd_hit,
   output logic [EW-1:0]   rd_entry
);
   logic [EW-1:0] mem [DEPTH];
   logic [PW:0]   slot_w;
   logic [PW-1:0] rd_slot;
   logic          hit;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && wr_ptr == PW'(g)) mem[g] <= wr_entry;
      end
   end

   always_comb begin
      if ({1'b0, wr_ptr} > {1'b0, rd_idx})
         slot_w = {1'b0, wr_ptr} - (PW+1)'(1) - {1'b0, rd_idx};
      else
         slot_w = {1'b0, wr_ptr} + (PW+1)'(DEPTH - 1) - {1'b0, rd_idx};
      rd_slot = slot_w[PW-1:0];
      hit     = CNTW'(rd_idx) < fill_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ack   <= 1'b0;
         rd_hit   <= 1'b0;
         rd_entry <= '0;
      end else begin
         rd_ack <= rd_req;
         if (rd_req) begin
            rd_hit   <= hit;
            rd_entry <= hit ? mem[rd_slot] : '0;
         end
      end
   end
endmodule

// File: rtl/dbg_trace_ring.sv
module dbg_trace_ring #(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int CW    = 4,
   parameter int DEPTH = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_data,
   input  logic [CW-1:0]   cpu_ctl,
   input  logic            trig_basic,
   input  logic            trig_comb,
   input  logic            trig_seq,
   input  logic [1:0]      src_sel,
   input  logic            freeze,
   input  logic            clear,
   input  logic            rd_req,
   input  logic [PW-1:0]   rd_idx,
   output logic            rd_ack,
   output logic            rd_hit,
   output logic [AW-1:0]   rd_addr,
   output logic [DW-1:0]   rd_data,
   output logic [CW-1:0]   rd_ctl,
   output logic [PW-1:0]   wr_ptr,
   output logic [CNTW-1:0] fill_cnt,
   output logic            wrapped
);
   localparam int EW = AW + DW + CW;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dbg_trace_ring: DEPTH must be at least 2");
      end
      if (AW < 1 || DW < 1 || CW < 1) begin : g_bad_width
         $error("dbg_trace_ring: field widths must be positive");
      end
   endgenerate

   logic          cap_fire;
   logic          wr_en;
   logic [EW-1:0] rd_entry;

   dtr_qualifier i_qual (
      .trig_basic (trig_basic),
      .trig_comb  (trig_comb),
      .trig_seq   (trig_seq),
      .src_sel    (src_sel),
      .freeze     (freeze),
      .cap_fire   (cap_fire)
   );

   dtr_ctrl #(.DEPTH(DEPTH), .PW(PW), .CNTW(CNTW)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .cap_fire (cap_fire),
      .wr_en    (wr_en),
      .wr_ptr   (wr_ptr),
      .fill_cnt (fill_cnt),
      .wrapped  (wrapped)
   );

   dtr_store #(.DEPTH(DEPTH), .EW(EW), .PW(PW), .CNTW(CNTW)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_ptr   (wr_ptr),
      .wr_entry ({cpu_addr, cpu_data, cpu_ctl}),
      .fill_cnt (fill_cnt),
      .rd_req   (rd_req),
      .rd_idx   (rd_idx),
      .rd_ack   (rd_ack),
      .rd_hit   (rd_hit),
      .rd_entry (rd_entry)
   );

   assign {rd_addr, rd_data, rd_ctl} = rd_entry;
endmodule

// File: rtl/dtr_chk.sv
module dtr_chk #(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int CW    = 4,
   parameter int DEPTH = 8,
   parameter int PW    = 3,
   parameter int CNTW  = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trig_basic,
   input logic            trig_comb,
   input logic            trig_seq,
   input logic [1:0]      src_sel,
   input logic            freeze,
   input logic            clear,
   input logic            rd_req,
   input logic            rd_ack,
   input logic            rd_hit,
   input logic [AW-1:0]   rd_addr,
   input logic [DW-1:0]   rd_data,
   input logic [CW-1:0]   rd_ctl,
   input logic [PW-1:0]   wr_ptr,
   input logic [CNTW-1:0] fill_cnt,
   input logic            wrapped
);
   logic sel_q;
   logic take;

   always_comb begin
      case (src_sel)
         2'd0:    sel_q = trig_basic;
         2'd1:    sel_q = trig_comb;
         2'd2:    sel_q = trig_seq;
         default: sel_q = 1'b1;
      endcase
      take = sel_q && !freeze && !clear;
   end

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CNTW'(DEPTH));

   // R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> wr_ptr == (($past(wr_ptr) == PW'(DEPTH - 1)) ? '0 : $past(wr_ptr) + PW'(1)));

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && fill_cnt < CNTW'(DEPTH) |=> fill_cnt == $past(fill_cnt) + CNTW'(1));

   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take && !clear |=> $stable(wr_ptr) && $stable(fill_cnt) && $stable(wrapped));

   // R7
   wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrapped && !clear |=> wrapped);

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> wr_ptr == '0 && fill_cnt == '0 && !wrapped);

   // R4
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_ack);

   // R4
   no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_ack);

   // R11
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack && !rd_hit |-> rd_addr == '0 && rd_data == '0 && rd_ctl == '0);
endmodule

bind dbg_trace_ring dtr_chk #(
   .AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH), .PW(PW), .CNTW(CNTW)
) i_dtr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig_basic (trig_basic),
   .trig_comb  (trig_comb),
   .trig_seq   (trig_seq),
   .src_sel    (src_sel),
   .freeze     (freeze),
   .clear      (clear),
   .rd_req     (rd_req),
   .rd_ack     (rd_ack),
   .rd_hit     (rd_hit),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .rd_ctl     (rd_ctl),
   .wr_ptr     (wr_ptr),
   .fill_cnt   (fill_cnt),
   .wrapped    (wrapped)
);

// File: tb/test_dbg_trace_ring.sv
module test_dbg_trace_ring;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0, cpu_data = '0;
   logic [3:0]  cpu_ctl = '0;
   logic        trig_basic = 0, trig_comb = 0, trig_seq = 0;
   logic [1:0]  src_sel = '0;
   logic        freeze = 0, clear = 0, rd_req = 0;
   logic [2:0]  rd_idx = '0;
   logic        rd_ack, rd_hit, wrapped;
   logic [15:0] rd_addr, rd_data;
   logic [3:0]  rd_ctl;
   logic [2:0]  wr_ptr;
   logic [3:0]  fill_cnt;

   dbg_trace_ring i_dbg_trace_ring (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_ctl(cpu_ctl), .trig_basic(trig_basic), .trig_comb(trig_comb),
      .trig_seq(trig_seq), .src_sel(src_sel), .freeze(freeze), .clear(clear),
      .rd_req(rd_req), .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_hit(rd_hit),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_ctl(rd_ctl),
      .wr_ptr(wr_ptr), .fill_cnt(fill_cnt), .wrapped(wrapped)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          due;
      logic        hit;
      logic [15:0] a, d;
      logic [3:0]  c;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic [35:0] mdl [8];
   int mptr = 0, mcnt = 0;
   bit mwrap = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_status(input string tag);
      chk(wr_ptr == 3'(mptr), tag, "wr_ptr", wr_ptr, mptr);
      chk(fill_cnt == 4'(mcnt), tag, "fill_cnt", fill_cnt, mcnt);
      chk(wrapped == mwrap, tag, "wrapped", wrapped, mwrap);
   endtask

   // drives one cycle, predicts its effect, then checks status after the edge
   task automatic step(input string tag, input logic [1:0] sel,
                       input bit b, input bit cm, input bit s,
                       input bit frz, input bit clr, input bit req, input int idx,
                       input logic [15:0] a, input logic [15:0] d, input logic [3:0] ct);
      bit sel_hit, fire;
      exp_t e;
      src_sel = sel; trig_basic = b; trig_comb = cm; trig_seq = s;
      freeze = frz; clear = clr; rd_req = req; rd_idx = 3'(idx);
      cpu_addr = a; cpu_data = d; cpu_ctl = ct;
      if (req) begin
         e.due = cyc + 1;
         e.tag = tag;
         if (idx < mcnt) begin
            e.hit = 1'b1;
            {e.a, e.d, e.c} = mdl[(mptr - 1 - idx + 16) % 8];
         end else begin
            e.hit = 1'b0; e.a = '0; e.d = '0; e.c = '0;
         end
         sb.push_back(e);
      end
      case (sel)
         2'd0: sel_hit = b;
         2'd1: sel_hit = cm;
         2'd2: sel_hit = s;
         default: sel_hit = 1'b1;
      endcase
      fire = sel_hit && !frz && !clr;
      if (clr) begin
         mptr = 0; mcnt = 0; mwrap = 0;
      end else if (fire) begin
         mdl[mptr] = {a, d, ct};
         if (mcnt == 8) mwrap = 1;
         else mcnt++;
         mptr = (mptr + 1) % 8;
      end
      @(posedge clk); #1;
      chk_status(tag);
   endtask

   task automatic idle(input string tag);
      step(tag, 2'd0, 0, 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 4'h0);
   endtask

   task automatic rd(input string tag, input int idx);
      step(tag, 2'd0, 0, 0, 0, 0, 0, 1, idx, 16'h0, 16'h0, 4'h0);
   endtask

   // monitor: compares read results in the cycle they are due
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(rd_ack == 1'b1, e.tag, "rd_ack", rd_ack, 1);
            chk(rd_hit == e.hit, e.tag, "rd_hit", rd_hit, e.hit);
            chk(rd_addr == e.a, e.tag, "rd_addr", rd_addr, e.a);
            chk(rd_data == e.d, e.tag, "rd_data", rd_data, e.d);
            chk(rd_ctl == e.c, e.tag, "rd_ctl", rd_ctl, e.c);
         end else if (rst_n && rd_ack) begin
            chk(1'b0, "R4", "stray rd_ack", rd_ack, 0);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk_status("R1");
      chk(rd_ack == 1'b0, "R1", "rd_ack", rd_ack, 0);
      // R11 read of an empty ring
      rd("R11", 0);
      // R2 unselected triggers ignored, selected captures
      step("R2", 2'd0, 0, 1, 1, 0, 0, 0, 0, 16'h1111, 16'hAAAA, 4'h1);
      step("R2", 2'd1, 1, 0, 1, 0, 0, 0, 0, 16'h2222, 16'hBBBB, 4'h2);
      step("R2", 2'd2, 1, 1, 0, 0, 0, 0, 0, 16'h3333, 16'hCCCC, 4'h3);
      step("R2", 2'd0, 1, 0, 0, 0, 0, 0, 0, 16'h0100, 16'h0001, 4'h4);
      step("R2", 2'd1, 0, 1, 0, 0, 0, 0, 0, 16'h0200, 16'h0002, 4'h5);
      step("R2", 2'd2, 0, 0, 1, 0, 0, 0, 0, 16'h0300, 16'h0003, 4'h6);
      // R3 R4 contents and age order
      for (int i = 0; i < 4; i++) rd("R3", i);
      rd("R11", 5);
      // R5 R6 R7 every-cycle capture past the depth
      for (int i = 0; i < 9; i++)
         step("R6", 2'd3, 0, 0, 0, 0, 0, 0, 0, 16'h4000 + 16'(i), 16'h9000 + 16'(i), 4'(i));
      for (int i = 0; i < 8; i++) rd("R5", i);
      // R8 freeze blocks capture in every mode
      for (int i = 0; i < 4; i++)
         step("R8", 2'(i), 1, 1, 1, 1, 0, 0, 0, 16'hDEAD, 16'hBEEF, 4'hF);
      rd("R8", 0);
      // R12 reads leave state alone
      for (int i = 0; i < 8; i++) rd("R12", 7 - i);
      // R10 read and capture at the same edge
      step("R10", 2'd3, 0, 0, 0, 0, 0, 1, 0, 16'h5A5A, 16'hA5A5, 4'h9);
      rd("R10", 0);
      // R9 clear beats a simultaneous capture
      step("R9", 2'd3, 0, 0, 0, 0, 1, 0, 0, 16'h7777, 16'h7777, 4'h7);
      rd("R9", 0);
      step("R9", 2'd0, 1, 0, 0, 0, 0, 0, 0, 16'h0ABC, 16'h0DEF, 4'hA);
      rd("R9", 0);
      rd("R9", 1);
      idle("R4");
      idle("R4");
      chk(sb.size() == 0, "R4", "pending reads", sb.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule